// File: doc/BRIEF.md
# Store Commit and Writeback Queue

This block holds the stores of an out-of-order core between allocation and the moment their write to the data cache is finished. Stores take slots in program order at the tail of a circular buffer. Address and data are filled in when the store executes. Commit names a sequence-number bound, and every store older than that bound becomes eligible to be written. A separate writeback pointer then offers the eligible stores to the cache one at a time, oldest first. A slot is returned to the free pool only when the cache reports that its write has completed. Completions may arrive in any order, but the head pointer only moves past a run of completed slots.

The buffer keeps one slot unused as a sentinel, so it holds `DEPTH-1` stores. A cache rejection sets a blocked state that silences the write request until the cache signals a retry, and the same store is then offered again. A pipeline squash removes every uncommitted store that is younger than a given sequence number and pulls the tail back over them. Write requests are also held back in any cycle in which loads already occupy all of the cache ports.

Top module: `store_wb_queue`

## Requirements
- R1: The queue holds at most DEPTH-1 stores. `full` is 1 and `alloc_ready` is 0 when occupancy equals DEPTH-1, and an allocation attempted while full has no effect. After reset, `alloc_idx` starts at slot 0 and moves up by one slot for each accepted allocation.
- R2: After reset, `occupancy`, `wb_pending`, `full`, `wr_valid` and `blocked` are all 0.
- R3: A commit with bound S marks every live, uncommitted store whose sequence number is below S as eligible for writeback. Stores with sequence number S or above are not marked. On the next cycle, `wb_pending` has grown by the number of stores that were newly marked.
- R4: `wr_valid` offers the oldest eligible store that has not yet been written, giving its slot on `wr_idx` and its executed address and data on `wr_addr` and `wr_data`. Each cycle with `wr_valid` and `wr_ready` both high moves on to the next store and lowers `wb_pending` by one. A store that has not been committed is never offered.
- R5: In a cycle with `wr_valid` high and `wr_ready` low, the store is rejected. `blocked` is 1 from the next cycle, and during that time `wr_valid` stays 0 and `wb_pending` does not change. A one-cycle pulse on `wr_retry` clears `blocked`, and the same slot is then offered again.
- R6: A slot is freed only after its write has completed. Neither commit nor issue frees a slot. The head slot is released one cycle after its completion is recorded, at most one slot per cycle. A younger store that completes first is not released before the older stores ahead of it.
- R7: `wr_valid` stays 0 in any cycle in which `ld_ports_taken` is at least CACHE_PORTS.
- R8: A squash with bound Q removes every uncommitted store whose sequence number is greater than Q. On the next cycle, occupancy has dropped by the number of stores removed, and the next allocation reuses the slot of the oldest store that was removed. Committed stores and `wb_pending` are not affected. No allocation is accepted in a squash cycle.
- R9: All pointers wrap from slot DEPTH-1 to slot 0, so allocation and write order stay in program order across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to allocate a store slot |
| alloc_seq | input | SEQ_W | Sequence number of the store being allocated |
| alloc_ready | output | 1 | The allocation is accepted this cycle |
| alloc_idx | output | IDX_W | Slot that the next allocation takes |
| exec_valid | input | 1 | Executed address and data are present |
| exec_idx | input | IDX_W | Slot to fill with address and data |
| exec_addr | input | ADDR_W | Store address |
| exec_data | input | DATA_W | Store data |
| commit_valid | input | 1 | Commit bound is present |
| commit_seq | input | SEQ_W | Stores below this sequence number commit |
| ld_ports_taken | input | PW | Cache ports already used by loads this cycle |
| wr_valid | output | 1 | Cache write request |
| wr_idx | output | IDX_W | Slot of the offered store |
| wr_addr | output | ADDR_W | Address of the offered store |
| wr_data | output | DATA_W | Data of the offered store |
| wr_ready | input | 1 | The cache accepts the write |
| wr_retry | input | 1 | The cache can take a rejected write again |
| done_valid | input | 1 | A store write has completed |
| done_idx | input | IDX_W | Slot of the completed store |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Stores younger than this are removed |
| occupancy | output | CNT_W | Number of live slots |
| wb_pending | output | CNT_W | Committed stores not yet written |
| full | output | 1 | Occupancy has reached DEPTH-1 |
| blocked | output | 1 | The cache rejected a write and no retry has arrived yet |

## Verification
The hardest state to reach is one where all three pointers are apart: a store has been sent but not completed, a store has been committed but not sent, and an uncommitted store lies behind both, with completions arriving in the wrong order. The stimulus keeps the cache ports occupied by loads, so the commit and the write issue can be moved apart cycle by cycle. It then completes a younger store before an older one and squashes the uncommitted tail while a committed store is still waiting. A later pass drives the tail and the writeback pointer across the wrap from the last slot to slot 0.

// File: rtl/swq_pkg.sv
package swq_pkg;
  // advance a circular index by one slot
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // step a circular index back by n slots
  function automatic int unsigned wrap_back(int unsigned p, int unsigned n,
                                            int unsigned depth);
    return (p >= n) ? p - n : p + depth - n;
  endfunction
endpackage

// File: rtl/swq_slot_bank.sv
module swq_slot_bank #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_we,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic              exec_we,
  input  logic [IDX_W-1:0]  exec_idx,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic [DATA_W-1:0] exec_data,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              issue_fire,
  input  logic [IDX_W-1:0]  issue_idx,
  input  logic              done_valid,
  input  logic [IDX_W-1:0]  done_idx,
  input  logic              release_fire,
  input  logic [IDX_W-1:0]  release_idx,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [IDX_W-1:0]  hd_idx,
  output logic [DEPTH-1:0]  valid_vec,
  output logic [DEPTH-1:0]  commit_new_vec,
  output logic [DEPTH-1:0]  squash_hit_vec,
  output logic              rd_valid,
  output logic              rd_canwb,
  output logic              rd_done,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              hd_released,
  output logic              done_live
);
  logic [DEPTH-1:0]  canwb_vec, done_vec, cmt_vec;
  logic [ADDR_W-1:0] addr_arr [DEPTH];
  logic [DATA_W-1:0] data_arr [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              v_q, cm_q, cw_q, dn_q;
    logic [SEQ_W-1:0]  s_q;
    logic [ADDR_W-1:0] a_q;
    logic [DATA_W-1:0] d_q;
    localparam logic [IDX_W-1:0] MY = IDX_W'(i);

    assign commit_new_vec[i] = commit_valid && v_q && !cm_q && (s_q < commit_seq);
    assign squash_hit_vec[i] = squash_valid && v_q && !cm_q && (s_q > squash_seq);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0; cm_q <= 1'b0; cw_q <= 1'b0; dn_q <= 1'b0;
        s_q <= '0;
      end else if (alloc_we && alloc_idx == MY) begin
        v_q <= 1'b1; cm_q <= 1'b0; cw_q <= 1'b0; dn_q <= 1'b0;
        s_q <= alloc_seq;
      end else begin
        if (squash_hit_vec[i] || (release_fire && release_idx == MY)) v_q <= 1'b0;
        if (commit_new_vec[i]) begin
          cm_q <= 1'b1;
          cw_q <= 1'b1;
        end
        if (issue_fire && issue_idx == MY) cw_q <= 1'b0;
        if (done_valid && done_idx == MY) dn_q <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        a_q <= '0;
        d_q <= '0;
      end else if (exec_we && exec_idx == MY) begin
        a_q <= exec_addr;
        d_q <= exec_data;
      end
    end

    assign valid_vec[i] = v_q;
    assign cmt_vec[i]   = cm_q;
    assign canwb_vec[i] = cw_q;
    assign done_vec[i]  = dn_q;
    assign addr_arr[i]  = a_q;
    assign data_arr[i]  = d_q;
  end

  assign rd_valid    = valid_vec[rd_idx];
  assign rd_canwb    = canwb_vec[rd_idx];
  assign rd_done     = done_vec[rd_idx];
  assign rd_addr     = addr_arr[rd_idx];
  assign rd_data     = data_arr[rd_idx];
  assign hd_released = valid_vec[hd_idx] && done_vec[hd_idx];
  // a completion may only name a live slot that has already been sent
  assign done_live   = valid_vec[done_idx] && cmt_vec[done_idx] && !canwb_vec[done_idx];
endmodule

// File: rtl/swq_wb_port.sv
module swq_wb_port #(
  parameter int CACHE_PORTS = 2,
  parameter int PW          = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  input  logic          rd_canwb,
  input  logic          rd_done,
  input  logic [PW-1:0] ld_ports_taken,
  input  logic          wr_ready,
  input  logic          wr_retry,
  output logic          wr_valid,
  output logic          issue_fire,
  output logic          reject_fire,
  output logic          blocked
);
  logic port_free;

  assign port_free   = ld_ports_taken < PW'(CACHE_PORTS);
  assign wr_valid    = rd_valid && rd_canwb && !rd_done && !blocked && port_free;
  assign issue_fire  = wr_valid && wr_ready;
  assign reject_fire = wr_valid && !wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)           blocked <= 1'b0;
    else if (reject_fire) blocked <= 1'b1;
    else if (wr_retry)    blocked <= 1'b0;
  end
endmodule

// File: rtl/store_wb_queue.sv
module store_wb_queue #(
  parameter int DEPTH       = 8,
  parameter int SEQ_W       = 16,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CACHE_PORTS = 2,
  localparam int IDX_W      = $clog2(DEPTH),
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int PW         = $clog2(CACHE_PORTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              exec_valid,
  input  logic [IDX_W-1:0]  exec_idx,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic [DATA_W-1:0] exec_data,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic [PW-1:0]     ld_ports_taken,
  output logic              wr_valid,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ready,
  input  logic              wr_retry,
  input  logic              done_valid,
  input  logic [IDX_W-1:0]  done_idx,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  output logic [CNT_W-1:0]  occupancy,
  output logic [CNT_W-1:0]  wb_pending,
  output logic              full,
  output logic              blocked
);
  import swq_pkg::*;

  logic [IDX_W-1:0] head_q, tail_q, wbp_q, tail_back;
  logic [DEPTH-1:0] valid_vec, commit_new_vec, squash_hit_vec;
  logic             alloc_fire, issue_fire, reject_fire, release_fire, done_live;
  logic             rd_valid, rd_canwb, rd_done;
  logic [CNT_W-1:0] n_commit, n_squash;

  assign full        = occupancy >= CNT_W'(DEPTH - 1);
  assign alloc_ready = !full && !squash_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_idx   = tail_q;
  assign wr_idx      = wbp_q;
  assign n_commit    = CNT_W'($countones(commit_new_vec));
  assign n_squash    = CNT_W'($countones(squash_hit_vec));
  assign tail_back   = IDX_W'(wrap_back(32'(tail_q), 32'(n_squash), DEPTH));

  swq_slot_bank #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) i_bank (
    .clk(clk), .rst_n(rst_n),
    .alloc_we(alloc_fire), .alloc_idx(tail_q), .alloc_seq(alloc_seq),
    .exec_we(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr), .exec_data(exec_data),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .issue_fire(issue_fire), .issue_idx(wbp_q),
    .done_valid(done_valid), .done_idx(done_idx),
    .release_fire(release_fire), .release_idx(head_q),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .rd_idx(wbp_q), .hd_idx(head_q),
    .valid_vec(valid_vec), .commit_new_vec(commit_new_vec), .squash_hit_vec(squash_hit_vec),
    .rd_valid(rd_valid), .rd_canwb(rd_canwb), .rd_done(rd_done),
    .rd_addr(wr_addr), .rd_data(wr_data),
    .hd_released(release_fire), .done_live(done_live)
  );

  swq_wb_port #(.CACHE_PORTS(CACHE_PORTS), .PW(PW)) i_wb (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_canwb(rd_canwb), .rd_done(rd_done),
    .ld_ports_taken(ld_ports_taken), .wr_ready(wr_ready), .wr_retry(wr_retry),
    .wr_valid(wr_valid), .issue_fire(issue_fire), .reject_fire(reject_fire),
    .blocked(blocked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q     <= '0;
      tail_q     <= '0;
      wbp_q      <= '0;
      occupancy  <= '0;
      wb_pending <= '0;
    end else begin
      if (release_fire) head_q <= IDX_W'(wrap_inc(32'(head_q), DEPTH));
      if (squash_valid)    tail_q <= tail_back;
      else if (alloc_fire) tail_q <= IDX_W'(wrap_inc(32'(tail_q), DEPTH));
      if (issue_fire)
        wbp_q <= IDX_W'(wrap_inc(32'(wbp_q), DEPTH));
      else if (squash_hit_vec[wbp_q])
        wbp_q <= tail_back;
      occupancy  <= occupancy + CNT_W'(alloc_fire) - CNT_W'(release_fire) - n_squash;
      wb_pending <= wb_pending + n_commit - CNT_W'(issue_fire);
    end
  end

  // R1: live slots never exceed the capacity left by the sentinel
  p_occ_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(DEPTH - 1));
  // R4: a store is only accepted while one is counted as waiting
  p_pending_cover_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> wb_pending != '0);
  // R5: a rejected write silences the request until a retry
  p_reject_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !wr_retry) |=> !wr_valid);
  // R5: the writeback pointer stays on a rejected store
  p_reject_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(wr_idx));
  // R6: completions only name live, already-sent slots
  p_done_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> done_live);
  // R7: no write request while loads hold every cache port
  p_port_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ld_ports_taken < PW'(CACHE_PORTS));
  // R8: a squash never removes a slot the head is about to release
  p_squash_spares_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
    release_fire |-> !squash_hit_vec[head_q]);
endmodule

// File: tb/test_store_wb_queue.sv
module test_store_wb_queue;
  localparam int DEPTH = 8;
  localparam int SEQ_W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [15:0] alloc_seq = '0;
  logic        alloc_ready;
  logic [2:0]  alloc_idx;
  logic        exec_valid = 1'b0;
  logic [2:0]  exec_idx = '0;
  logic [31:0] exec_addr = '0, exec_data = '0;
  logic        commit_valid = 1'b0;
  logic [15:0] commit_seq = '0;
  logic [1:0]  ld_ports_taken = 2'd2;
  logic        wr_valid;
  logic [2:0]  wr_idx;
  logic [31:0] wr_addr, wr_data;
  logic        wr_ready = 1'b1, wr_retry = 1'b0;
  logic        done_valid = 1'b0;
  logic [2:0]  done_idx = '0;
  logic        squash_valid = 1'b0;
  logic [15:0] squash_seq = '0;
  logic [3:0]  occupancy, wb_pending;
  logic        full, blocked;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  store_wb_queue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(32), .DATA_W(32),
                   .CACHE_PORTS(2)) i_store_wb_queue (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_ready(alloc_ready),
    .alloc_idx(alloc_idx),
    .exec_valid(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
    .exec_data(exec_data),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .ld_ports_taken(ld_ports_taken),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .wr_retry(wr_retry),
    .done_valid(done_valid), .done_idx(done_idx),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .occupancy(occupancy), .wb_pending(wb_pending), .full(full), .blocked(blocked)
  );

  function automatic logic [31:0] addr_of(int s); return 32'h1000 + 32'(s) * 16; endfunction
  function automatic logic [31:0] data_of(int s); return 32'hA500_0000 | 32'(s); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic alloc_one(int s, int exp_idx, string req);
    alloc_valid = 1'b1; alloc_seq = 16'(s);
    exec_valid = 1'b1; exec_idx = alloc_idx; exec_addr = addr_of(s); exec_data = data_of(s);
    #1 check(req, 32'(alloc_idx), 32'(exp_idx));
    step();
    alloc_valid = 1'b0; exec_valid = 1'b0;
  endtask

  task automatic commit_to(int s);
    commit_valid = 1'b1; commit_seq = 16'(s);
    step();
    commit_valid = 1'b0;
  endtask

  task automatic issue_one(int exp_idx, int s, string req);
    ld_ports_taken = 2'd0;
    #1;
    check({req, " valid"}, 32'(wr_valid), 1);
    check({req, " idx"}, 32'(wr_idx), 32'(exp_idx));
    check({req, " addr"}, wr_addr, addr_of(s));
    check({req, " data"}, wr_data, data_of(s));
    step();
    ld_ports_taken = 2'd2;
  endtask

  task automatic pulse_done(int idx);
    done_valid = 1'b1; done_idx = 3'(idx);
    step();
    done_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R2 occupancy", 32'(occupancy), 0);
    check("R2 wb_pending", 32'(wb_pending), 0);
    check("R2 full", 32'(full), 0);
    check("R2 wr_valid", 32'(wr_valid), 0);
    check("R2 blocked", 32'(blocked), 0);
    check("R1 first alloc_idx", 32'(alloc_idx), 0);
  endtask

  task automatic t_fill();
    for (int s = 1; s <= 7; s++) alloc_one(s, s - 1, "R1 alloc order");
    check("R1 occupancy at capacity", 32'(occupancy), 7);
    check("R1 full", 32'(full), 1);
    check("R1 alloc_ready when full", 32'(alloc_ready), 0);
    alloc_valid = 1'b1; alloc_seq = 16'd99;
    step();
    alloc_valid = 1'b0;
    check("R1 alloc while full ignored", 32'(occupancy), 7);
  endtask

  task automatic t_commit_reject();
    commit_to(4);
    check("R3 pending after commit", 32'(wb_pending), 3);
    check("R7 no request with ports busy", 32'(wr_valid), 0);
    ld_ports_taken = 2'd1;
    #1 check("R7 request with a free port", 32'(wr_valid), 1);
    check("R4 oldest offered", 32'(wr_idx), 0);
    wr_ready = 1'b0;
    step();
    wr_ready = 1'b1;
    check("R5 blocked after reject", 32'(blocked), 1);
    #1 check("R5 silent while blocked", 32'(wr_valid), 0);
    step();
    check("R5 still silent", 32'(wr_valid), 0);
    check("R5 pending unchanged", 32'(wb_pending), 3);
    ld_ports_taken = 2'd2;
    wr_retry = 1'b1;
    step();
    wr_retry = 1'b0;
    check("R5 retry clears", 32'(blocked), 0);
    issue_one(0, 1, "R5 same store resent");
    issue_one(1, 2, "R4 second");
    issue_one(2, 3, "R4 third");
    check("R4 pending drained", 32'(wb_pending), 0);
    ld_ports_taken = 2'd0;
    #1 check("R3 uncommitted not offered", 32'(wr_valid), 0);
    ld_ports_taken = 2'd2;
    check("R6 issue frees nothing", 32'(occupancy), 7);
  endtask

  task automatic t_out_of_order();
    pulse_done(1);
    step();
    check("R6 younger done not released", 32'(occupancy), 7);
    pulse_done(0);
    check("R6 release one cycle later", 32'(occupancy), 7);
    step();
    check("R6 head released", 32'(occupancy), 6);
    step();
    check("R6 contiguous release", 32'(occupancy), 5);
    pulse_done(2);
    step();
    check("R6 third released", 32'(occupancy), 4);
  endtask

  task automatic t_squash();
    commit_to(5);
    check("R3 only older committed", 32'(wb_pending), 1);
    squash_valid = 1'b1; squash_seq = 16'd5;
    #1 check("R8 no alloc during squash", 32'(alloc_ready), 0);
    step();
    squash_valid = 1'b0;
    check("R8 occupancy after squash", 32'(occupancy), 2);
    check("R8 committed pending kept", 32'(wb_pending), 1);
    alloc_one(10, 5, "R8 tail retreats");
    issue_one(3, 4, "R8 committed store survives");
    pulse_done(3);
    step();
    check("R8 occupancy", 32'(occupancy), 2);
    commit_to(11);
    check("R3 two committed", 32'(wb_pending), 2);
    issue_one(4, 5, "R4 after squash a");
    issue_one(5, 10, "R4 after squash b");
    pulse_done(4);
    pulse_done(5);
    step(); step();
    check("R6 drained", 32'(occupancy), 0);
  endtask

  task automatic t_wrap();
    alloc_one(20, 6, "R8 alloc before squash");
    squash_valid = 1'b1; squash_seq = 16'd15;
    step();
    squash_valid = 1'b0;
    check("R8 sole entry squashed", 32'(occupancy), 0);
    alloc_one(21, 6, "R9 slot six");
    alloc_one(22, 7, "R9 slot seven");
    alloc_one(23, 0, "R9 wrap to zero");
    commit_to(24);
    check("R9 pending", 32'(wb_pending), 3);
    issue_one(6, 21, "R9 write six");
    issue_one(7, 22, "R9 write seven");
    issue_one(0, 23, "R9 write wrapped");
    pulse_done(6);
    pulse_done(7);
    pulse_done(0);
    step(); step();
    check("R9 empty after wrap", 32'(occupancy), 0);
    check("R9 next alloc idx", 32'(alloc_idx), 1);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_fill();
    t_commit_reject();
    t_out_of_order();
    t_squash();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule